// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Gating

This block keeps the return addresses of a small 8-bit microcontroller core in hardware. A subroutine call pushes the address to return to. A return or return-from-interrupt pops it. The top entry is always presented to the program-counter logic. The stack holds eight entries. A call made while the stack is full still succeeds: the new address is stored and the oldest one is given up, so the eight most recent addresses stay usable.

Interrupts are handled differently from calls. A non-masked interrupt request is latched into a pending flag. The acknowledge is raised only when the global enable is set, the stack has a free slot, and no call or pop is being made in the same cycle. While the stack is full the request waits. One pop frees a slot, and the acknowledge follows in the next quiet cycle. An acknowledge pushes the supplied return address and clears the pending flag.

Storage uses a circular write pointer. A separate occupancy counter runs from 0 to 8 and saturates at 8. When a pop and a push fall in the same cycle, the pop is applied first.

Top module: `ras_irq_stack`

## Requirements
- R1: The stack holds up to DEPTH (default 8) entries. `full_o` is 1 exactly when the occupancy is DEPTH, and `level_o` never exceeds DEPTH.
- R2: `top_o` shows the most recently pushed entry that has not been popped, in last-in first-out order.
- R3: A call on a full stack stores its address as the new top, and `level_o` stays at DEPTH.
- R4: After one or more overflowing calls, successive pops return the DEPTH most recent addresses, newest first.
- R5: An interrupt request arriving while the stack is full sets `irq_pend_o` one cycle later, and `irq_ack_o` stays 0 for as long as `full_o` is 1.
- R6: `irq_ack_o` is 1 in a cycle exactly when all of these hold: `irq_pend_o` is 1, `irq_en_i` is 1, `full_o` is 0, `call_i` is 0 and `pop_i` is 0. An acknowledge pushes `ret_addr_i`.
- R7: An acknowledge clears `irq_pend_o` at the next edge, unless a new request arrives in that same cycle.
- R8: While `irq_en_i` is 0, a pending request stays pending and is not acknowledged.
- R9: A call and a pop in the same cycle pop first and then push. On a non-empty stack the level is unchanged and the top becomes the new address. On an empty stack the level becomes 1.
- R10: A pop on an empty stack leaves `level_o` at 0 and `top_o` unchanged.
- R11: After reset the stack is empty, `full_o` is 0, and both `irq_pend_o` and `irq_ack_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call: push `ret_addr_i` |
| pop_i | input | 1 | Return or return-from-interrupt: pop the top entry |
| ret_addr_i | input | AW | Return address to push on a call or an acknowledge |
| irq_req_i | input | 1 | Non-masked interrupt request pulse |
| irq_en_i | input | 1 | Global interrupt enable |
| top_o | output | AW | Current top-of-stack address |
| level_o | output | $clog2(DEPTH+1) | Occupancy, 0 to DEPTH |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |
| irq_pend_o | output | 1 | Latched interrupt request awaiting acknowledge |
| irq_ack_o | output | 1 | Interrupt acknowledged this cycle (combinational) |

## Verification
The registered results (`top_o`, `level_o`, `full_o`, `empty_o`, `irq_pend_o`) change one clock edge after the call, pop or request that causes them. `irq_ack_o` is combinational, so it is valid in the same cycle as the inputs that produce it. The bench changes inputs just after a rising edge and compares every output at the following falling edge against a queue-based model. The model is advanced only after that comparison, so each registered expectation belongs to the previous edge and each acknowledge expectation belongs to the current inputs. Directed checks read registered outputs just after an edge, one cycle after their stimulus.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_SWAP = 2'b11
    } stk_op_e;

endpackage

// File: rtl/ras_store.sv
module ras_store
    import ras_pkg::*;
#(
    parameter int AW    = 13,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] din_i,
    output logic [AW-1:0] top_o,
    output logic [LW-1:0] level_o,
    output logic          full_o,
    output logic          empty_o
);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] mem;
        logic [PW-1:0]            wptr;
        logic [LW-1:0]            lvl;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
    endfunction

    stk_op_e op;
    logic    pop_ok;

    always_comb begin
        st_d   = st_q;
        pop_ok = pop_i && (st_q.lvl != '0);
        op     = stk_op_e'({push_i, pop_ok});
        unique case (op)
            OP_POP: begin
                st_d.wptr = ptr_dec(st_q.wptr);
                st_d.lvl  = st_q.lvl - LW'(1);
            end
            OP_PUSH: begin
                st_d.mem[st_q.wptr] = din_i;
                st_d.wptr           = ptr_inc(st_q.wptr);
                if (st_q.lvl != LW'(DEPTH))
                    st_d.lvl = st_q.lvl + LW'(1);
            end
            OP_SWAP: begin
                st_d.mem[ptr_dec(st_q.wptr)] = din_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_o   = st_q.mem[ptr_dec(st_q.wptr)];
    assign level_o = st_q.lvl;
    assign full_o  = (st_q.lvl == LW'(DEPTH));
    assign empty_o = (st_q.lvl == '0);

endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req_i,
    input  logic irq_en_i,
    input  logic full_i,
    input  logic call_i,
    input  logic pop_i,
    output logic pend_o,
    output logic ack_o
);

    typedef struct packed {
        logic pend;
    } gate_t;

    gate_t g_d, g_q;
    logic  ack;

    always_comb begin
        ack      = g_q.pend && irq_en_i && !full_i && !call_i && !pop_i;
        g_d.pend = (g_q.pend && !ack) || irq_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign pend_o = g_q.pend;
    assign ack_o  = ack;

endmodule

// File: rtl/ras_irq_stack.sv
module ras_irq_stack #(
    parameter int AW    = 13,
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          pop_i,
    input  logic [AW-1:0] ret_addr_i,
    input  logic          irq_req_i,
    input  logic          irq_en_i,
    output logic [AW-1:0] top_o,
    output logic [LW-1:0] level_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          irq_pend_o,
    output logic          irq_ack_o
);

    logic push;

    assign push = call_i || irq_ack_o;

    ras_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop_i),
        .din_i   (ret_addr_i),
        .top_o   (top_o),
        .level_o (level_o),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    ras_irq_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req_i (irq_req_i),
        .irq_en_i  (irq_en_i),
        .full_i    (full_o),
        .call_i    (call_i),
        .pop_i     (pop_i),
        .pend_o    (irq_pend_o),
        .ack_o     (irq_ack_o)
    );

endmodule

// File: rtl/ras_irq_stack_chk.sv
module ras_irq_stack_chk #(
    parameter int AW    = 13,
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          call_i,
    input logic          pop_i,
    input logic [AW-1:0] ret_addr_i,
    input logic          irq_req_i,
    input logic          irq_en_i,
    input logic [AW-1:0] top_o,
    input logic [LW-1:0] level_o,
    input logic          full_o,
    input logic          empty_o,
    input logic          irq_pend_o,
    input logic          irq_ack_o
);

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LW'(DEPTH));

    assert_call_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && call_i && !pop_i) |=> (full_o && top_o == $past(ret_addr_i)));

    assert_no_ack_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !irq_ack_o);

    assert_ack_needs_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> (irq_pend_o && !call_i && !pop_i));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_o && !irq_req_i) |=> !irq_pend_o);

    assert_disabled_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o && !irq_en_i) |=> irq_pend_o);

    assert_swap_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && pop_i && !empty_o) |=> ($stable(level_o) && top_o == $past(ret_addr_i)));

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !call_i && empty_o) |=> (empty_o && $stable(top_o)));

endmodule

bind ras_irq_stack ras_irq_stack_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_i     (call_i),
    .pop_i      (pop_i),
    .ret_addr_i (ret_addr_i),
    .irq_req_i  (irq_req_i),
    .irq_en_i   (irq_en_i),
    .top_o      (top_o),
    .level_o    (level_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .irq_pend_o (irq_pend_o),
    .irq_ack_o  (irq_ack_o)
);

// File: tb/sim_ras_irq_stack.sv
`timescale 1ns/1ps
module sim_ras_irq_stack;

    localparam int AW    = 13;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_i = 1'b0, pop_i = 1'b0, irq_req_i = 1'b0, irq_en_i = 1'b0;
    logic [AW-1:0] ret_addr_i = '0;
    logic [AW-1:0] top_o;
    logic [LW-1:0] level_o;
    logic          full_o, empty_o, irq_pend_o, irq_ack_o;

    always #5 clk = ~clk;

    ras_irq_stack #(.AW(AW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .pop_i(pop_i),
        .ret_addr_i(ret_addr_i), .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
        .top_o(top_o), .level_o(level_o), .full_o(full_o), .empty_o(empty_o),
        .irq_pend_o(irq_pend_o), .irq_ack_o(irq_ack_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [AW-1:0] mq[$];
    bit            mpend = 0;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Drive one cycle; compare at the falling edge, then advance the model.
    task automatic cyc(input bit c, input bit p, input logic [AW-1:0] a,
                       input bit r, input bit e);
        bit ack_exp;
        call_i = c; pop_i = p; ret_addr_i = a; irq_req_i = r; irq_en_i = e;
        @(negedge clk);
        ack_exp = mpend && e && !c && !p && (mq.size() < DEPTH);
        chk("R6",  "ack",   int'(irq_ack_o), int'(ack_exp));
        chk("R1",  "full",  int'(full_o), int'(mq.size() == DEPTH));
        chk("R3",  "level", int'(level_o), mq.size());
        chk("R10", "empty", int'(empty_o), int'(mq.size() == 0));
        chk("R7",  "pend",  int'(irq_pend_o), int'(mpend));
        if (mq.size() > 0) chk("R2", "top", int'(top_o), int'(mq[$]));
        if (p && mq.size() > 0) void'(mq.pop_back());
        if (c || ack_exp) begin
            mq.push_back(a);
            if (mq.size() > DEPTH) void'(mq.pop_front());
        end
        mpend = (mpend && !ack_exp) || r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] held;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "level", int'(level_o), 0);
        chk("R11", "full",  int'(full_o), 0);
        chk("R11", "empty", int'(empty_o), 1);
        chk("R11", "pend",  int'(irq_pend_o), 0);
        chk("R11", "ack",   int'(irq_ack_o), 0);
        @(posedge clk); #1;

        for (int i = 0; i < DEPTH; i++) cyc(1, 0, AW'(13'h100 + i), 0, 1);
        chk("R1", "full after 8", int'(full_o), 1);
        chk("R2", "top after 8", int'(top_o), 13'h107);

        cyc(1, 0, 13'h1A0, 0, 1);
        cyc(1, 0, 13'h1A1, 0, 1);
        chk("R3", "level on overflow", int'(level_o), DEPTH);
        chk("R3", "top on overflow", int'(top_o), 13'h1A1);

        cyc(0, 0, 13'h0AA, 1, 1);
        chk("R5", "pend while full", int'(irq_pend_o), 1);
        cyc(0, 0, 13'h0AA, 0, 1);
        cyc(0, 0, 13'h0AA, 0, 1);
        chk("R5", "still pending", int'(irq_pend_o), 1);
        chk("R5", "level held", int'(level_o), DEPTH);

        cyc(0, 1, 13'h0AA, 0, 1);
        chk("R4", "top after pop", int'(top_o), 13'h1A0);
        cyc(0, 0, 13'h0AA, 0, 1);
        chk("R6", "ack pushed addr", int'(top_o), 13'h0AA);
        chk("R7", "pend cleared", int'(irq_pend_o), 0);

        cyc(0, 1, 13'h0, 0, 1);
        for (int i = 0; i < DEPTH - 1; i++) begin
            chk("R4", "unwind order", int'(top_o),
                (i == 0) ? 13'h1A0 : 13'h107 - (i - 1));
            cyc(0, 1, 13'h0, 0, 1);
        end
        chk("R4", "oldest lost", int'(level_o), 0);

        held = top_o;
        cyc(0, 1, 13'h0, 0, 1);
        chk("R10", "level on empty pop", int'(level_o), 0);
        chk("R10", "top on empty pop", int'(top_o), int'(held));

        cyc(1, 1, 13'h155, 0, 1);
        chk("R9", "swap on empty level", int'(level_o), 1);
        chk("R9", "swap on empty top", int'(top_o), 13'h155);
        cyc(1, 1, 13'h166, 0, 1);
        chk("R9", "swap level", int'(level_o), 1);
        chk("R9", "swap top", int'(top_o), 13'h166);

        cyc(0, 0, 13'h0BB, 1, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 13'h0BB, 0, 0);
        chk("R8", "held while disabled", int'(irq_pend_o), 1);
        chk("R8", "no push while disabled", int'(level_o), 1);
        cyc(0, 0, 13'h0BB, 0, 1);
        chk("R8", "ack after enable", int'(top_o), 13'h0BB);

        cyc(0, 0, 13'h0CC, 1, 1);
        cyc(0, 0, 13'h0CD, 1, 1);
        chk("R7", "re-request keeps pend", int'(irq_pend_o), 1);

        for (int i = 0; i < 3000; i++) begin
            bit c, p, r, e;
            c = ($urandom % 3) == 0;
            p = ($urandom % 3) == 0;
            r = ($urandom % 5) == 0;
            e = ($urandom % 4) != 0;
            cyc(c, p, AW'($urandom), r, e);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule